// File: doc/BRIEF.md
# Serial NOR Flash Command Sequencer

This block is the byte-level command front end of a serial NOR flash slave. A shift register outside the block hands it each received byte with a strobe, and a pulse when chip select goes inactive. The block asks that shift register for nothing. It answers transmit requests from its own reply buffer, or by issuing memory reads. The first byte after chip select is an opcode. Depending on the opcode, the sequencer collects address, mode, dummy or parameter bytes, or loads a reply of up to four bytes.

The block holds the protection and mode state of the device: the write-enable latch, the reset arm, quad enable, 4-byte addressing, an extended address byte and a volatile configuration byte. When collection completes, it raises single-cycle read, program-write or erase requests on a shared address bus. The storage array and the erase timing live elsewhere. Every request and the error flag come from registers, and each appears in the clock cycle after the strobe that caused it.

Top module: `nor_cmd_seq`

## Requirements
- R1: After read (0x03), page program (0x02) or sector erase (0xD8), exactly 3 address bytes are collected, or 4 while 4-byte mode is on, most significant byte first, before the command acts; a transmit request before the last byte has no effect.
- R2: Fast read (0x0B) collects the address, then as many dummy bytes as configuration bits [7:4]; quad I/O read (0xEB) collects one extra mode byte on top of that; only then does the streaming read start.
- R3: With 3-byte addressing, the extended address byte is placed above the three received bytes; every assembled address is truncated to ADDR_W bits.
- R4: Replies: status read (0x05) gives write-enable in bit 1 and quad enable in bit 6, other bits 0; configuration read (0x15) gives the configuration byte with bit 5 replaced by the 4-byte flag; 0xC8 gives the extended address; 0x85 gives the raw configuration byte; ID read (0x9F) gives ID_VAL[23:16], [15:8], [7:0]; once a reply is used up, its last byte repeats.
- R5: Reset-enable (0x66) arms a reset; any other opcode disarms it; memory reset (0x99) acts only while armed.
- R6: A memory reset clears the current address, the extended address, 4-byte mode, write enable, the reset arm and quad enable, and leaves the sequencer idle; the configuration byte keeps its value.
- R7: Status write (0x01), extended-address write (0xC5) and configuration write (0x81) take one parameter byte only when write enable is set, and otherwise are ignored; a completed status write loads quad enable from parameter bit 6 and clears write enable.
- R8: Bulk erase (0xC7) raises one erase request with erase_all set and address 0 only while write enable is set; otherwise nothing is issued.
- R9: 0xB7 and 0xE9 set and clear 4-byte mode; 0x06 and 0x04 set and clear the write-enable latch; 0x35 and 0xF5 set and clear quad enable.
- R10: After program address collection, each further received byte gives one prog_wr at the current address with that byte, and the address then increments; sector erase gives one erase request at the assembled address with erase_all low.
- R11: In the streaming read, each tx_req gives one rd_req at the current address, then increments it, wrapping from the last array address to 0.
- R12: A chip-select release returns the sequencer to idle from any state and takes priority over a byte strobed in the same cycle, which is then dropped.
- R13: Any other opcode raises err_unknown for one cycle and leaves every flag and register unchanged except the reset arm.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| cs_release | input | 1 | Chip select went inactive (pulse) |
| tx_req | input | 1 | Shift register wants the next byte to send |
| tx_byte | output | 8 | Current reply byte (0 outside a reply) |
| rd_req | output | 1 | Memory read request |
| prog_wr | output | 1 | Memory program write |
| erase_req | output | 1 | Erase request |
| erase_all | output | 1 | Erase request covers the whole array |
| err_unknown | output | 1 | Unknown opcode seen |
| mem_addr | output | ADDR_W | Address for the current request |
| prog_data | output | 8 | Data byte for prog_wr |

## Verification
The bench builds the sequencer with ADDR_W = 25. At that width the low bit of the extended address lands inside the array and the next bit is cut off. The upper bits of a 4-byte address are dropped too, and the wrap from 0x1FFFFFF back to 0 takes only a few transmit requests. The configuration byte starts at 0x20. That gives two dummy bytes, so the bench can see a transmit request being ignored partway through the dummy phase, and the preset bit 5 shows the 4-byte flag overriding it in the configuration reply. A later configuration write of 0 covers the case with no dummy bytes.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;
  localparam logic [7:0] OP_READ   = 8'h03;
  localparam logic [7:0] OP_FAST   = 8'h0B;
  localparam logic [7:0] OP_QIO    = 8'hEB;
  localparam logic [7:0] OP_PROG   = 8'h02;
  localparam logic [7:0] OP_SERASE = 8'hD8;
  localparam logic [7:0] OP_BERASE = 8'hC7;
  localparam logic [7:0] OP_WREN   = 8'h06;
  localparam logic [7:0] OP_WRDI   = 8'h04;
  localparam logic [7:0] OP_RDSR   = 8'h05;
  localparam logic [7:0] OP_RDCR   = 8'h15;
  localparam logic [7:0] OP_WRSR   = 8'h01;
  localparam logic [7:0] OP_EN4    = 8'hB7;
  localparam logic [7:0] OP_EX4    = 8'hE9;
  localparam logic [7:0] OP_RDEXT  = 8'hC8;
  localparam logic [7:0] OP_WREXT  = 8'hC5;
  localparam logic [7:0] OP_RDCFG  = 8'h85;
  localparam logic [7:0] OP_WRCFG  = 8'h81;
  localparam logic [7:0] OP_RSTEN  = 8'h66;
  localparam logic [7:0] OP_RST    = 8'h99;
  localparam logic [7:0] OP_RDID   = 8'h9F;
  localparam logic [7:0] OP_QEN    = 8'h35;
  localparam logic [7:0] OP_QDIS   = 8'hF5;

  typedef enum logic [2:0] {S_IDLE, S_COLLECT, S_REPLY, S_READ, S_PROG, S_DONE} seq_state_e;
  typedef enum logic [2:0] {A_NONE, A_READ, A_PROG, A_ERASE, A_WRSR, A_WREXT, A_WRCFG} act_e;
  typedef enum logic [1:0] {K_DONE, K_COLLECT, K_REPLY, K_UNKNOWN} kind_e;
endpackage

// File: rtl/nor_op_decode.sv
module nor_op_decode
  import nor_seq_pkg::*;
#(
  parameter int          CNT_W  = 5,
  parameter logic [23:0] ID_VAL = 24'h000000
) (
  input  logic [7:0]       op,
  input  logic             four_b,
  input  logic             wel,
  input  logic             qe,
  input  logic [7:0]       ext,
  input  logic [7:0]       cfg,
  output kind_e            kind,
  output act_e             act,
  output logic [CNT_W-1:0] need,
  output logic [2:0]       rlen,
  output logic [31:0]      rdata
);
  logic [CNT_W-1:0] alen;
  logic [CNT_W-1:0] dummy;

  assign alen  = four_b ? CNT_W'(4) : CNT_W'(3);
  assign dummy = CNT_W'(cfg[7:4]);

  always_comb begin
    kind  = K_DONE;
    act   = A_NONE;
    need  = '0;
    rlen  = 3'd1;
    rdata = '0;
    case (op)
      OP_READ:   begin kind = K_COLLECT; act = A_READ;  need = alen; end
      OP_PROG:   begin kind = K_COLLECT; act = A_PROG;  need = alen; end
      OP_SERASE: begin kind = K_COLLECT; act = A_ERASE; need = alen; end
      OP_FAST:   begin kind = K_COLLECT; act = A_READ;  need = alen + dummy; end
      OP_QIO:    begin kind = K_COLLECT; act = A_READ;  need = alen + CNT_W'(1) + dummy; end
      OP_WRSR:   if (wel) begin kind = K_COLLECT; act = A_WRSR;  need = CNT_W'(1); end
      OP_WREXT:  if (wel) begin kind = K_COLLECT; act = A_WREXT; need = CNT_W'(1); end
      OP_WRCFG:  if (wel) begin kind = K_COLLECT; act = A_WRCFG; need = CNT_W'(1); end
      OP_RDSR:   begin kind = K_REPLY; rdata[7:0] = {1'b0, qe, 4'b0000, wel, 1'b0}; end
      OP_RDCR:   begin kind = K_REPLY; rdata[7:0] = {cfg[7:6], four_b, cfg[4:0]}; end
      OP_RDEXT:  begin kind = K_REPLY; rdata[7:0] = ext; end
      OP_RDCFG:  begin kind = K_REPLY; rdata[7:0] = cfg; end
      OP_RDID:   begin
        kind  = K_REPLY;
        rlen  = 3'd3;
        rdata = {8'h00, ID_VAL[7:0], ID_VAL[15:8], ID_VAL[23:16]};
      end
      OP_WREN, OP_WRDI, OP_EN4, OP_EX4, OP_BERASE,
      OP_RSTEN, OP_RST, OP_QEN, OP_QDIS: kind = K_DONE;
      default: kind = K_UNKNOWN;
    endcase
  end
endmodule

// File: rtl/nor_reply_buf.sv
module nor_reply_buf #(
  parameter int BYTES = 4,
  localparam int IDX_W = $clog2(BYTES),
  localparam int LEN_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] load_len,
  input  logic [8*BYTES-1:0] load_data,
  input  logic             adv,
  output logic [7:0]       out_byte
);
  logic [8*BYTES-1:0] data_q, data_n;
  logic [LEN_W-1:0]   len_q, len_n;
  logic [IDX_W-1:0]   idx_q, idx_n;

  always_comb begin
    data_n = data_q;
    len_n  = len_q;
    idx_n  = idx_q;
    if (load) begin
      data_n = load_data;
      len_n  = load_len;
      idx_n  = '0;
    end else if (adv && ({1'b0, idx_q} + LEN_W'(1) < len_q)) begin
      idx_n = idx_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      len_q  <= '0;
      idx_q  <= '0;
    end else begin
      data_q <= data_n;
      len_q  <= len_n;
      idx_q  <= idx_n;
    end
  end

  assign out_byte = data_q[{idx_q, 3'b000} +: 8];

  // R4: the read index never runs past the loaded reply
  p_idx_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (len_q != '0) |-> ({1'b0, idx_q} < len_q));
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int          ADDR_W  = 26,
  parameter logic [7:0]  CFG_RST = 8'h80,
  parameter logic [23:0] ID_VAL  = 24'hC22539
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic              cs_release,
  input  logic              tx_req,
  output logic [7:0]        tx_byte,
  output logic              rd_req,
  output logic              prog_wr,
  output logic              erase_req,
  output logic              erase_all,
  output logic              err_unknown,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        prog_data
);
  localparam int CNT_W = $clog2(4 + 1 + 16);

  seq_state_e        st_q, st_n;
  act_e              act_q, act_n;
  logic [CNT_W-1:0]  need_q, need_n, cnt_q, cnt_n;
  logic [31:0]       abuf_q, abuf_n;
  logic [ADDR_W-1:0] cur_q, cur_n, maddr_q, maddr_n, asm_addr;
  logic [7:0]        ext_q, ext_n, cfg_q, cfg_n, pdata_q, pdata_n;
  logic              wel_q, wel_n, rsten_q, rsten_n, qe_q, qe_n, four_q, four_n;
  logic              rd_n, pw_n, er_n, ea_n, err_n;
  logic              rd_q, pw_q, er_q, ea_q, err_q;
  logic              rb_load, rb_adv;
  logic [7:0]        rb_out;
  kind_e             dec_kind;
  act_e              dec_act;
  logic [CNT_W-1:0]  dec_need;
  logic [2:0]        dec_rlen;
  logic [31:0]       dec_rdata;
  logic [CNT_W-1:0]  alen;

  nor_op_decode #(.CNT_W(CNT_W), .ID_VAL(ID_VAL)) u_dec (
    .op(rx_byte), .four_b(four_q), .wel(wel_q), .qe(qe_q), .ext(ext_q), .cfg(cfg_q),
    .kind(dec_kind), .act(dec_act), .need(dec_need), .rlen(dec_rlen), .rdata(dec_rdata)
  );

  nor_reply_buf #(.BYTES(4)) u_rbuf (
    .clk(clk), .rst_n(rst_n), .load(rb_load), .load_len(dec_rlen),
    .load_data(dec_rdata), .adv(rb_adv), .out_byte(rb_out)
  );

  assign alen     = four_q ? CNT_W'(4) : CNT_W'(3);
  assign asm_addr = ADDR_W'(four_q ? abuf_n : {ext_q, abuf_n[23:0]});

  always_comb begin
    st_n = st_q; act_n = act_q; need_n = need_q; cnt_n = cnt_q; abuf_n = abuf_q;
    cur_n = cur_q; ext_n = ext_q; cfg_n = cfg_q; wel_n = wel_q; rsten_n = rsten_q;
    qe_n = qe_q; four_n = four_q; maddr_n = maddr_q; pdata_n = pdata_q;
    rd_n = 1'b0; pw_n = 1'b0; er_n = 1'b0; ea_n = 1'b0; err_n = 1'b0;
    rb_load = 1'b0; rb_adv = 1'b0;
    if (cs_release) begin
      st_n = S_IDLE;
    end else begin
      case (st_q)
        S_IDLE: if (rx_valid) begin
          rsten_n = (rx_byte == OP_RSTEN);
          st_n    = S_DONE;
          case (dec_kind)
            K_COLLECT: begin st_n = S_COLLECT; act_n = dec_act; need_n = dec_need; cnt_n = '0; end
            K_REPLY:   begin st_n = S_REPLY; rb_load = 1'b1; end
            K_UNKNOWN: err_n = 1'b1;
            default: ;
          endcase
          case (rx_byte)
            OP_WREN: wel_n  = 1'b1;
            OP_WRDI: wel_n  = 1'b0;
            OP_EN4:  four_n = 1'b1;
            OP_EX4:  four_n = 1'b0;
            OP_QEN:  qe_n   = 1'b1;
            OP_QDIS: qe_n   = 1'b0;
            OP_BERASE: if (wel_q) begin er_n = 1'b1; ea_n = 1'b1; maddr_n = '0; end
            OP_RST: if (rsten_q) begin
              cur_n = '0; ext_n = '0; four_n = 1'b0; wel_n = 1'b0; qe_n = 1'b0;
              st_n  = S_IDLE;
            end
            default: ;
          endcase
        end
        S_COLLECT: if (rx_valid) begin
          if (cnt_q < alen) abuf_n = {abuf_q[23:0], rx_byte};
          cnt_n = cnt_q + CNT_W'(1);
          if (cnt_q + CNT_W'(1) == need_q) begin
            st_n = S_DONE;
            case (act_q)
              A_READ:  begin st_n = S_READ; cur_n = asm_addr; end
              A_PROG:  begin st_n = S_PROG; cur_n = asm_addr; end
              A_ERASE: begin er_n = 1'b1; maddr_n = asm_addr; end
              A_WRSR:  begin qe_n = rx_byte[6]; wel_n = 1'b0; end
              A_WREXT: ext_n = rx_byte;
              A_WRCFG: cfg_n = rx_byte;
              default: ;
            endcase
          end
        end
        S_REPLY: rb_adv = tx_req;
        S_READ: if (tx_req) begin
          rd_n = 1'b1; maddr_n = cur_q; cur_n = cur_q + ADDR_W'(1);
        end
        S_PROG: if (rx_valid) begin
          pw_n = 1'b1; maddr_n = cur_q; pdata_n = rx_byte; cur_n = cur_q + ADDR_W'(1);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; act_q <= A_NONE; need_q <= '0; cnt_q <= '0; abuf_q <= '0;
      cur_q <= '0; ext_q <= '0; cfg_q <= CFG_RST; wel_q <= 1'b0; rsten_q <= 1'b0;
      qe_q <= 1'b0; four_q <= 1'b0; maddr_q <= '0; pdata_q <= '0;
      rd_q <= 1'b0; pw_q <= 1'b0; er_q <= 1'b0; ea_q <= 1'b0; err_q <= 1'b0;
    end else begin
      st_q <= st_n; act_q <= act_n; need_q <= need_n; cnt_q <= cnt_n; abuf_q <= abuf_n;
      cur_q <= cur_n; ext_q <= ext_n; cfg_q <= cfg_n; wel_q <= wel_n; rsten_q <= rsten_n;
      qe_q <= qe_n; four_q <= four_n; maddr_q <= maddr_n; pdata_q <= pdata_n;
      rd_q <= rd_n; pw_q <= pw_n; er_q <= er_n; ea_q <= ea_n; err_q <= err_n;
    end
  end

  assign tx_byte     = (st_q == S_REPLY) ? rb_out : 8'h00;
  assign rd_req      = rd_q;
  assign prog_wr     = pw_q;
  assign erase_req   = er_q;
  assign erase_all   = ea_q;
  assign err_unknown = err_q;
  assign mem_addr    = maddr_q;
  assign prog_data   = pdata_q;

  // R12: chip-select release always lands in idle
  p_cs_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cs_release |=> (st_q == S_IDLE));
  // R8: a whole-array erase only follows a set write-enable latch
  p_bulk_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_req && erase_all) |-> $past(wel_q));
  // R5: the reset arm only rises on the arming opcode
  p_arm_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsten_q) |-> $past(rx_valid && rx_byte == OP_RSTEN));
  // R7: a completed status write leaves write enable clear
  p_wrsr_clears_wel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_COLLECT && act_q == A_WRSR && rx_valid && !cs_release &&
     cnt_q + CNT_W'(1) == need_q) |=> !wel_q);
  // R13: unknown opcodes leave the mode flags alone
  p_unknown_keeps_r13: assert property (@(posedge clk) disable iff (!rst_n)
    err_unknown |-> (wel_q == $past(wel_q) && four_q == $past(four_q) &&
                     qe_q == $past(qe_q) && ext_q == $past(ext_q) && cfg_q == $past(cfg_q)));
  // R10: at most one request kind per cycle
  p_one_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_req, prog_wr, erase_req, err_unknown}));
endmodule

// File: tb/nor_cmd_seq_tb.sv
module nor_cmd_seq_tb;
  localparam int AW = 25;
  localparam logic [31:0] MASK = (32'd1 << AW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 1'b0, cs_release = 1'b0, tx_req = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic [7:0] tx_byte, prog_data;
  logic rd_req, prog_wr, erase_req, erase_all, err_unknown;
  logic [AW-1:0] mem_addr;

  always #2 clk = ~clk;

  nor_cmd_seq #(.ADDR_W(AW), .CFG_RST(8'h20), .ID_VAL(24'hC22539)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .cs_release(cs_release), .tx_req(tx_req), .tx_byte(tx_byte),
    .rd_req(rd_req), .prog_wr(prog_wr), .erase_req(erase_req), .erase_all(erase_all),
    .err_unknown(err_unknown), .mem_addr(mem_addr), .prog_data(prog_data)
  );

  typedef struct {
    int          kind;  // 0 read, 1 program, 2 erase, 3 error
    logic [31:0] addr;
    logic [7:0]  data;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0, errors = 0, seen = 0;
  bit done = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic expect_ev(input int k, input logic [31:0] a, input logic [7:0] d, input string tag);
    exp_t e;
    e.kind = k; e.addr = a & MASK; e.data = d; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic pull();
    @(negedge clk); tx_req = 1'b1;
    @(negedge clk); tx_req = 1'b0;
  endtask

  task automatic release_cs();
    @(negedge clk); cs_release = 1'b1;
    @(negedge clk); cs_release = 1'b0;
  endtask

  task automatic reply1(input logic [7:0] op, input logic [7:0] exp, input string tag);
    send(op);
    check(tag, {24'h0, tx_byte}, {24'h0, exp});
    release_cs();
  endtask

  // monitor: pops expected items as the design raises requests
  always @(negedge clk) begin
    if (rst_n && (rd_req || prog_wr || erase_req || err_unknown)) begin
      int k;
      exp_t e;
      seen++;
      k = rd_req ? 0 : prog_wr ? 1 : erase_req ? 2 : 3;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected request kind %0d addr %h (actual), none expected", k, mem_addr);
      end else begin
        e = exp_q.pop_front();
        if (k != e.kind || (k != 3 && {7'h0, mem_addr} !== e.addr) ||
            (k == 1 && prog_data !== e.data) || (k == 2 && {7'h0, erase_all} !== {7'h0, e.data[0]})) begin
          errors++;
          $display("FAIL %s: actual kind %0d addr %h data %h ea %b expected kind %0d addr %h data %h",
                   e.tag, k, mem_addr, prog_data, erase_all, e.kind, e.addr, e.data);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int s0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("reset tx_byte", {24'h0, tx_byte}, 32'h0);
    check("reset no request", seen, 0);

    // R4 status and configuration replies, R9 flag opcodes
    reply1(8'h05, 8'h00, "R4 status after reset");
    reply1(8'h15, 8'h00, "R4 cfg bit5 forced low");
    send(8'hB7); release_cs();
    send(8'h15);
    check("R9 cfg shows 4-byte", {24'h0, tx_byte}, 32'h20);
    pull();
    check("R4 repeat last byte", {24'h0, tx_byte}, 32'h20);
    release_cs();
    send(8'h06); release_cs();
    reply1(8'h05, 8'h02, "R9 write enable set");
    send(8'h04); release_cs();
    reply1(8'h05, 8'h00, "R9 write enable cleared");

    // R7 gating of extended address write
    send(8'hC5); send(8'h03); release_cs();
    reply1(8'hC8, 8'h00, "R7 ext write ignored");
    send(8'h06); release_cs();
    send(8'hC5); send(8'h03); release_cs();
    reply1(8'hC8, 8'h03, "R7 ext write taken");

    // R3 3-byte assembly with extended byte, R11 streaming
    send(8'hE9); release_cs();
    send(8'h03); send(8'h12); send(8'h34); send(8'h56);
    expect_ev(0, 32'h03123456, 8'h0, "R3 ext prefix");
    pull();
    expect_ev(0, 32'h03123457, 8'h0, "R11 increment");
    pull();
    release_cs();

    // R1 4-byte collection, early tx_req ignored, R11 wrap
    send(8'hB7); release_cs();
    s0 = seen;
    send(8'h03); send(8'hFF); send(8'hFF); send(8'hFF);
    pull(); @(negedge clk);
    check("R1 no read before 4th byte", seen, s0);
    send(8'hFE);
    expect_ev(0, 32'hFFFFFFFE, 8'h0, "R1 4-byte addr");
    pull();
    expect_ev(0, 32'h01FFFFFF, 8'h0, "R11 last address");
    pull();
    expect_ev(0, 32'h0, 8'h0, "R11 wrap");
    pull();
    release_cs();

    // R2 fast read with two dummy bytes, quad read with mode byte
    send(8'hE9); release_cs();
    s0 = seen;
    send(8'h0B); send(8'hA1); send(8'hB2); send(8'hC3); send(8'hD1);
    pull(); @(negedge clk);
    check("R2 still in dummy", seen, s0);
    send(8'hD2);
    expect_ev(0, 32'h03A1B2C3, 8'h0, "R2 fast read");
    pull();
    release_cs();
    send(8'hEB); send(8'h00); send(8'h00); send(8'h10); send(8'hA0); send(8'h00);
    pull(); @(negedge clk);
    check("R2 quad needs extra byte", seen, s0 + 1);
    send(8'h00);
    expect_ev(0, 32'h03000010, 8'h0, "R2 quad read");
    pull();
    release_cs();
    send(8'h81); send(8'h00); release_cs();
    reply1(8'h85, 8'h00, "R7 cfg write taken");
    send(8'h0B); send(8'h00); send(8'h00); send(8'h08);
    expect_ev(0, 32'h03000008, 8'h0, "R2 zero dummy");
    pull();
    release_cs();

    // R10 program and sector erase
    send(8'h02); send(8'h00); send(8'h00); send(8'h20);
    expect_ev(1, 32'h03000020, 8'h5A, "R10 program 0");
    send(8'h5A);
    expect_ev(1, 32'h03000021, 8'h6B, "R10 program 1");
    send(8'h6B);
    release_cs();
    expect_ev(2, 32'h03001000, 8'h0, "R10 sector erase");
    send(8'hD8); send(8'h00); send(8'h10); send(8'h00);
    release_cs();

    // R8 bulk erase gated by write enable
    expect_ev(2, 32'h0, 8'h1, "R8 bulk erase");
    send(8'hC7); release_cs();
    send(8'h04); release_cs();
    s0 = seen;
    send(8'hC7); @(negedge clk);
    check("R8 bulk erase blocked", seen, s0);
    release_cs();

    // R7 status write gating and effect
    send(8'h01); send(8'h40); release_cs();
    reply1(8'h05, 8'h00, "R7 status write ignored");
    send(8'h06); release_cs();
    send(8'h01); send(8'h40); release_cs();
    reply1(8'h05, 8'h40, "R7 status write sets qe clears wel");

    // R13 unknown opcode
    expect_ev(3, 32'h0, 8'h0, "R13 error flag");
    send(8'h77); release_cs();
    reply1(8'h05, 8'h40, "R13 flags unchanged");

    // R4 ID reply with repeat
    send(8'h9F);
    check("R4 id byte 0", {24'h0, tx_byte}, 32'hC2);
    pull(); check("R4 id byte 1", {24'h0, tx_byte}, 32'h25);
    pull(); check("R4 id byte 2", {24'h0, tx_byte}, 32'h39);
    pull(); check("R4 id repeat", {24'h0, tx_byte}, 32'h39);
    release_cs();

    // R5 arming, R6 reset effect
    send(8'hB7); release_cs();
    send(8'h99); release_cs();
    reply1(8'h05, 8'h40, "R5 unarmed reset ignored");
    send(8'h66); release_cs();
    send(8'h05); release_cs();
    send(8'h99); release_cs();
    reply1(8'h15, 8'h20, "R5 disarmed by other opcode");
    send(8'h66); release_cs();
    send(8'h99); release_cs();
    reply1(8'h05, 8'h00, "R6 qe and wel cleared");
    reply1(8'h15, 8'h00, "R6 4-byte cleared");
    reply1(8'hC8, 8'h00, "R6 ext cleared");

    // R12 release mid-collection, and release beating a byte
    send(8'h03); send(8'h11); send(8'h22); release_cs();
    send(8'h9F);
    check("R12 release aborts collection", {24'h0, tx_byte}, 32'hC2);
    release_cs();
    @(negedge clk); cs_release = 1'b1; rx_valid = 1'b1; rx_byte = 8'h06;
    @(negedge clk); cs_release = 1'b0; rx_valid = 1'b0;
    reply1(8'h05, 8'h00, "R12 simultaneous byte dropped");

    repeat (4) @(negedge clk);
    check("all expected requests seen", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule